// File: doc/BRIEF.md
# Asynchronous EPROM read controller

This block sits on the synchronous side of a chip and fetches bytes from an external asynchronous 128K x 8 one-time-programmable memory. A host issues a request with a 17-bit byte address. The controller drives the address and pulls chip enable low, then pulls output enable low after a fixed delay. It registers the data bus on the clock edge that ends the access budget, and it returns the byte with a one-cycle done pulse. Every delay is given in picoseconds and turned into whole clock cycles by rounding up. The defaults suit a 100 MHz clock and the fast speed grade: 5 cycles from chip enable to sample, output enable delayed by 3 cycles, and a 2-cycle float gap.

After each access both strobes go high. The controller then holds off the next access until the memory's output drivers have released the bus. A second request kind reads the two identification bytes. It raises a high-voltage request for the A9 line one cycle before chip enable falls, and drives every address bit low except A0. It reads the manufacturer byte (A0=0) and then the device byte (A0=1). It drops the high-voltage request one cycle after the final chip-enable rise, and it flags whether the pair matched the expected codes. The A9 address bit is driven logically low in this mode. An external analog stage applies the identification voltage while `id_hv_req` is high.

Top module: `eprom_rd_ctrl`

## Requirements
- R1: After reset, req_ready=1, mem_ce_n=1, mem_oe_n=1, id_hv_req=0, rsp_done=0 and id_ok=0.
- R2: A read is accepted on a rising edge where req_valid=1 and req_ready=1. On that edge mem_addr takes req_addr and mem_ce_n falls. mem_addr stays unchanged for as long as mem_ce_n stays low.
- R3: mem_oe_n falls 3 cycles after mem_ce_n falls (default parameters), and mem_oe_n is never low while mem_ce_n is high.
- R4: The data bus is registered 5 cycles after mem_ce_n falls. On that same edge rsp_done rises for exactly one cycle, rsp_data shows the byte, and both strobes rise. rsp_data holds its value until the next done pulse.
- R5: After the strobes rise, req_ready stays low for 2 cycles. With a request waiting, the next mem_ce_n fall comes 3 cycles after the rise.
- R6: req_ready is low from acceptance until the float gap ends. A request presented while req_ready is low and withdrawn before req_ready returns starts no access.
- R7: An identification request (req_id=1) raises id_hv_req on the accepting edge, and mem_ce_n falls one cycle later. The first access uses mem_addr=0 and the second uses mem_addr=1.
- R8: An identification read gives two done pulses: the byte at A0=0, then the byte at A0=1. The two accesses are separated by the 2-cycle float gap. id_hv_req falls one cycle after the second mem_ce_n rise, and req_ready returns one cycle after that.
- R9: On the second identification done pulse, id_ok becomes 1 exactly when the bytes were 0x1E then 0x05, and 0 otherwise. id_ok clears when an identification request is accepted, and normal reads leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_id | input | 1 | 1 = identification read, 0 = normal read |
| req_addr | input | 17 | Byte address for a normal read |
| req_ready | output | 1 | Controller idle, request can be taken |
| rsp_done | output | 1 | One-cycle pulse, rsp_data valid |
| rsp_data | output | 8 | Last byte read |
| id_ok | output | 1 | Identification pair matched |
| mem_addr | output | 17 | Memory address bus |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_data_i | input | 8 | Memory data bus |
| id_hv_req | output | 1 | Request for identification voltage on A9 |

## Verification
The hardest case to reach is a request that arrives while an access or its float gap is still running. If that request is withdrawn before req_ready comes back, it must leave no trace. The bench drives such a request in the middle of an access and drops it during the gap. It then counts chip-enable falls and checks the latched address for many cycles afterwards. A second hard case is a request held across the gap: the bench keeps req_valid high through two back-to-back accesses and measures the turnaround in cycles. A memory model in the bench puts a marker value on the bus whenever either strobe is high, so a sample taken too early shows up as wrong data.

// File: rtl/eprom_rd_pkg.sv
package eprom_rd_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_HV,
    ST_ACC,
    ST_GAP
  } rd_state_t;

  // whole cycles covering a delay, rounded up
  function automatic int cyc_ceil(input int delay_ps, input int period_ps);
    return (delay_ps + period_ps - 1) / period_ps;
  endfunction

  function automatic int at_least_one(input int v);
    return (v < 1) ? 1 : v;
  endfunction

  // cycles OE may trail CE without lengthening the access
  function automatic int oe_offset(input int acc_cyc, input int oe_cyc);
    return (acc_cyc > oe_cyc) ? (acc_cyc - oe_cyc) : 0;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/eprom_cyc_timer.sv
module eprom_cyc_timer #(
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          clr,
  output logic [CW-1:0] cnt
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else if (run) cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/eprom_seq_fsm.sv
module eprom_seq_fsm
  import eprom_rd_pkg::*;
#(
  parameter int AW      = 17,
  parameter int CW      = 3,
  parameter int ACC_CYC = 5,
  parameter int OE_DLY  = 3,
  parameter int DF_CYC  = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_id,
  input  logic [AW-1:0] req_addr,
  input  logic [CW-1:0] cnt,
  output logic          req_ready,
  output logic          cnt_clr,
  output logic          cnt_run,
  output logic [AW-1:0] mem_addr,
  output logic          ce_n,
  output logic          oe_n,
  output logic          hv_req,
  output logic          sample_evt,
  output logic          id_mode,
  output logic          id_second,
  output logic          id_start
);

  rd_state_t state;
  logic accept, acc_end, gap_end, gap_first;

  assign req_ready  = (state == ST_IDLE);
  assign accept     = req_valid && req_ready;
  assign id_start   = accept && req_id;
  assign acc_end    = (state == ST_ACC) && (cnt == CW'(ACC_CYC - 1));
  assign gap_end    = (state == ST_GAP) && (cnt == CW'(DF_CYC - 1));
  assign gap_first  = (state == ST_GAP) && (cnt == '0);
  assign sample_evt = acc_end;
  assign cnt_clr    = accept || (state == ST_HV) || acc_end || gap_end;
  assign cnt_run    = (state == ST_ACC) || (state == ST_GAP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      ce_n      <= 1'b1;
      oe_n      <= 1'b1;
      hv_req    <= 1'b0;
      mem_addr  <= '0;
      id_mode   <= 1'b0;
      id_second <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (accept) begin
            id_mode   <= req_id;
            id_second <= 1'b0;
            if (req_id) begin
              state  <= ST_HV;
              hv_req <= 1'b1;
            end else begin
              state    <= ST_ACC;
              ce_n     <= 1'b0;
              oe_n     <= (OE_DLY > 0);
              mem_addr <= req_addr;
            end
          end
        end
        ST_HV: begin
          state    <= ST_ACC;
          ce_n     <= 1'b0;
          oe_n     <= (OE_DLY > 0);
          mem_addr <= AW'(0);
        end
        ST_ACC: begin
          if (acc_end) begin
            state <= ST_GAP;
            ce_n  <= 1'b1;
            oe_n  <= 1'b1;
          end else begin
            oe_n <= ((int'(cnt) + 1) < OE_DLY);
          end
        end
        ST_GAP: begin
          if (gap_first && id_mode && id_second) hv_req <= 1'b0;
          if (gap_end) begin
            if (id_mode && !id_second) begin
              id_second <= 1'b1;
              state     <= ST_ACC;
              ce_n      <= 1'b0;
              oe_n      <= (OE_DLY > 0);
              mem_addr  <= AW'(1);
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R3
  oe_within_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> !ce_n);

  // R2
  addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && $past(!ce_n)) |-> $stable(mem_addr));

  // R7
  hv_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ce_n) && id_mode) |-> $past(hv_req));

  // R8
  hv_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hv_req) |-> (ce_n && $past(ce_n)));

  // R6
  busy_no_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n) |-> !req_ready);

endmodule

// File: rtl/eprom_capture.sv
module eprom_capture #(
  parameter int         DW     = 8,
  parameter logic [7:0] MFR_ID = 8'h1E,
  parameter logic [7:0] DEV_ID = 8'h05
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sample_evt,
  input  logic          id_start,
  input  logic          id_mode,
  input  logic          id_second,
  input  logic [DW-1:0] mem_data_i,
  output logic          rsp_done,
  output logic [DW-1:0] rsp_data,
  output logic          id_ok
);

  logic [DW-1:0] first_id;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_done <= 1'b0;
      rsp_data <= '0;
      id_ok    <= 1'b0;
      first_id <= '0;
    end else begin
      rsp_done <= sample_evt;
      if (sample_evt) rsp_data <= mem_data_i;
      if (id_start) id_ok <= 1'b0;
      if (sample_evt && id_mode && !id_second) first_id <= mem_data_i;
      if (sample_evt && id_mode && id_second)
        id_ok <= (first_id == DW'(MFR_ID)) && (mem_data_i == DW'(DEV_ID));
    end
  end

  // R4
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);

  // R4
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_done |-> $stable(rsp_data));

endmodule

// File: rtl/eprom_rd_ctrl.sv
module eprom_rd_ctrl
  import eprom_rd_pkg::*;
#(
  parameter int         CLK_PS = 10000,
  parameter int         TACC_PS = 45000,
  parameter int         TOE_PS = 20000,
  parameter int         TDF_PS = 20000,
  parameter int         AW = 17,
  parameter int         DW = 8,
  parameter logic [7:0] MFR_ID = 8'h1E,
  parameter logic [7:0] DEV_ID = 8'h05
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_id,
  input  logic [AW-1:0] req_addr,
  output logic          req_ready,
  output logic          rsp_done,
  output logic [DW-1:0] rsp_data,
  output logic          id_ok,
  output logic [AW-1:0] mem_addr,
  output logic          mem_ce_n,
  output logic          mem_oe_n,
  input  logic [DW-1:0] mem_data_i,
  output logic          id_hv_req
);

  localparam int ACC_CYC = at_least_one(cyc_ceil(TACC_PS, CLK_PS));
  localparam int OE_CYC  = at_least_one(cyc_ceil(TOE_PS, CLK_PS));
  localparam int OE_DLY  = oe_offset(ACC_CYC, OE_CYC);
  localparam int DF_CYC  = at_least_one(cyc_ceil(TDF_PS, CLK_PS));
  localparam int CW      = $clog2(max2(ACC_CYC, DF_CYC) + 1);

  logic [CW-1:0] cnt;
  logic cnt_clr, cnt_run, sample_evt, id_mode, id_second, id_start;

  eprom_cyc_timer #(.CW(CW)) i_timer (
    .clk(clk), .rst_n(rst_n), .run(cnt_run), .clr(cnt_clr), .cnt(cnt)
  );

  eprom_seq_fsm #(
    .AW(AW), .CW(CW), .ACC_CYC(ACC_CYC), .OE_DLY(OE_DLY), .DF_CYC(DF_CYC)
  ) i_fsm (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_id(req_id),
    .req_addr(req_addr), .cnt(cnt), .req_ready(req_ready),
    .cnt_clr(cnt_clr), .cnt_run(cnt_run), .mem_addr(mem_addr),
    .ce_n(mem_ce_n), .oe_n(mem_oe_n), .hv_req(id_hv_req),
    .sample_evt(sample_evt), .id_mode(id_mode), .id_second(id_second),
    .id_start(id_start)
  );

  eprom_capture #(.DW(DW), .MFR_ID(MFR_ID), .DEV_ID(DEV_ID)) i_cap (
    .clk(clk), .rst_n(rst_n), .sample_evt(sample_evt), .id_start(id_start),
    .id_mode(id_mode), .id_second(id_second), .mem_data_i(mem_data_i),
    .rsp_done(rsp_done), .rsp_data(rsp_data), .id_ok(id_ok)
  );

  // R4
  sample_strobes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_evt |-> (!mem_ce_n && !mem_oe_n));

  // R4
  done_follows_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> $past(sample_evt));

endmodule

// File: tb/test_eprom_rd_ctrl.sv
`timescale 1ns/1ps
module test_eprom_rd_ctrl;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_id = 1'b0;
  logic [16:0] req_addr = '0;
  logic req_ready, rsp_done, id_ok, mem_ce_n, mem_oe_n, id_hv_req;
  logic [7:0] rsp_data, mem_data, mem_val;
  logic [16:0] mem_addr;
  logic bad_id = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  eprom_rd_ctrl i_eprom_rd_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_id(req_id),
    .req_addr(req_addr), .req_ready(req_ready), .rsp_done(rsp_done),
    .rsp_data(rsp_data), .id_ok(id_ok), .mem_addr(mem_addr),
    .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_data_i(mem_data),
    .id_hv_req(id_hv_req)
  );

  function automatic logic [7:0] pat(input logic [16:0] a);
    return a[7:0] ^ a[15:8] ^ {a[16], 7'b0} ^ 8'h3C;
  endfunction

  // memory model: marker 0xA5 whenever not driven
  always_comb begin
    if (id_hv_req && mem_addr[16:1] == '0)
      mem_val = mem_addr[0] ? (bad_id ? 8'h06 : 8'h05) : 8'h1E;
    else
      mem_val = pat(mem_addr);
  end
  assign mem_data = (!mem_ce_n && !mem_oe_n) ? mem_val : 8'hA5;

  int total = 0, bad = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // port monitor, sampled mid-cycle
  int ce_fall_n = 0, done_n = 0, oe_fall_n = 0, ce_rise_n = 0;
  int ce_fall_cyc [0:63];
  logic [16:0] ce_fall_addr [0:63];
  int oe_fall_cyc [0:63];
  int ce_rise_cyc [0:63];
  int done_cyc [0:63];
  logic [7:0] done_data [0:63];
  logic done_idok [0:63];
  int ready_rise_cyc = 0, hv_rise_cyc = 0, hv_fall_cyc = 0;
  int oe_viol = 0;
  logic p_ce = 1'b1, p_oe = 1'b1, p_rdy = 1'b1, p_hv = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (p_ce && !mem_ce_n) begin
        ce_fall_cyc[ce_fall_n % 64] = cyc;
        ce_fall_addr[ce_fall_n % 64] = mem_addr;
        ce_fall_n++;
      end
      if (!p_ce && mem_ce_n) begin ce_rise_cyc[ce_rise_n % 64] = cyc; ce_rise_n++; end
      if (p_oe && !mem_oe_n) begin oe_fall_cyc[oe_fall_n % 64] = cyc; oe_fall_n++; end
      if (rsp_done) begin
        done_cyc[done_n % 64] = cyc;
        done_data[done_n % 64] = rsp_data;
        done_idok[done_n % 64] = id_ok;
        done_n++;
      end
      if (!p_rdy && req_ready) ready_rise_cyc = cyc;
      if (!p_hv && id_hv_req) hv_rise_cyc = cyc;
      if (p_hv && !id_hv_req) hv_fall_cyc = cyc;
      if (!mem_oe_n && mem_ce_n) oe_viol++;
      p_ce = mem_ce_n; p_oe = mem_oe_n; p_rdy = req_ready; p_hv = id_hv_req;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic issue(input logic id, input logic [16:0] a, output int acc);
    @(negedge clk);
    req_valid = 1'b1; req_id = id; req_addr = a;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    acc = cyc;
    req_valid = 1'b0; req_id = 1'b0;
  endtask

  task automatic wait_done(input int n);
    int t = 0;
    while (done_n < n && t < 200) begin @(negedge clk); t++; end
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    // R1
    chk("R1 ready", req_ready, 1);
    chk("R1 ce_n", mem_ce_n, 1);
    chk("R1 oe_n", mem_oe_n, 1);
    chk("R1 hv", id_hv_req, 0);
    chk("R1 done", rsp_done, 0);
    chk("R1 id_ok", id_ok, 0);
  endtask

  task automatic t_read(input logic [16:0] a);
    int acc, f, d;
    f = ce_fall_n; d = done_n;
    issue(1'b0, a, acc);
    wait_done(d + 1);
    // R2
    chk("R2 ce fall cycle", ce_fall_cyc[f % 64] - acc, 0);
    chk("R2 address", int'(ce_fall_addr[f % 64]), int'(a));
    // R3
    chk("R3 oe delay", oe_fall_cyc[f % 64] - ce_fall_cyc[f % 64], 3);
    // R4
    chk("R4 done cycle", done_cyc[d % 64] - ce_fall_cyc[f % 64], 5);
    chk("R4 data", done_data[d % 64], pat(a));
    chk("R4 ce rise at done", ce_rise_cyc[f % 64], done_cyc[d % 64]);
    chk("R4 data held", rsp_data, pat(a));
    // R5
    chk("R5 ready return", ready_rise_cyc - done_cyc[d % 64], 2);
    // R6
    chk("R6 single access", ce_fall_n - f, 1);
  endtask

  task automatic t_back2back(input logic [16:0] a, input logic [16:0] b);
    int f, d, w;
    f = ce_fall_n; d = done_n;
    @(negedge clk);
    req_valid = 1'b1; req_id = 1'b0; req_addr = a;
    w = 0;
    while (ce_fall_n == f && w < 50) begin @(negedge clk); w++; end
    req_addr = b;
    w = 0;
    while (ce_fall_n == f + 1 && w < 50) begin @(negedge clk); w++; end
    req_valid = 1'b0;
    wait_done(d + 2);
    // R5
    chk("R5 turnaround", ce_fall_cyc[(f + 1) % 64] - ce_rise_cyc[f % 64], 3);
    chk("R5 first data", done_data[d % 64], pat(a));
    chk("R5 second data", done_data[(d + 1) % 64], pat(b));
    chk("R5 second addr", int'(ce_fall_addr[(f + 1) % 64]), int'(b));
  endtask

  task automatic t_busy_ignore(input logic [16:0] a, input logic [16:0] junk);
    int acc, f, d;
    f = ce_fall_n; d = done_n;
    issue(1'b0, a, acc);
    @(negedge clk);
    req_valid = 1'b1; req_addr = junk;
    repeat (2) @(negedge clk);
    req_valid = 1'b0;
    wait_done(d + 1);
    repeat (10) @(negedge clk);
    // R6
    chk("R6 busy request ignored", ce_fall_n - f, 1);
    chk("R6 data of accepted", done_data[d % 64], pat(a));
    chk("R6 ready idle", req_ready, 1);
    chk("R6 ce idle", mem_ce_n, 1);
  endtask

  task automatic t_ident(input logic corrupt, input int exp_ok);
    int acc, f, d;
    bad_id = corrupt;
    f = ce_fall_n; d = done_n;
    issue(1'b1, 17'h1FFFF, acc);
    wait_done(d + 2);
    // R7
    chk("R7 hv rise", hv_rise_cyc - acc, 0);
    chk("R7 ce after hv", ce_fall_cyc[f % 64] - acc, 1);
    chk("R7 addr byte0", int'(ce_fall_addr[f % 64]), 0);
    chk("R7 addr byte1", int'(ce_fall_addr[(f + 1) % 64]), 1);
    // R8
    chk("R8 mfr byte", done_data[d % 64], 8'h1E);
    chk("R8 dev byte", done_data[(d + 1) % 64], corrupt ? 8'h06 : 8'h05);
    chk("R8 gap", ce_fall_cyc[(f + 1) % 64] - ce_rise_cyc[f % 64], 2);
    chk("R8 hv drop", hv_fall_cyc - ce_rise_cyc[(f + 1) % 64], 1);
    chk("R8 ready", ready_rise_cyc - hv_fall_cyc, 1);
    // R9
    chk("R9 id_ok at done", done_idok[(d + 1) % 64], exp_ok);
    chk("R9 id_ok low mid", done_idok[d % 64], 0);
    bad_id = 1'b0;
  endtask

  task automatic t_idok_keep();
    t_read(17'h00055);
    // R9
    chk("R9 id_ok kept by normal read", id_ok, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_read(17'h1ABCD);
    t_read(17'h00000);
    t_read(17'h1FFFF);
    t_back2back(17'h00012, 17'h10F0F);
    t_busy_ignore(17'h04444, 17'h1EEEE);
    t_ident(1'b0, 1);
    t_idok_keep();
    t_ident(1'b1, 0);
    // R3
    chk("R3 oe never low with ce high", oe_viol, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule